// File: doc/BRIEF.md
# Integer ALU with Carry Chaining and Multiply-High

This is the purely combinational arithmetic and logic unit of a small processor core. It takes two operands, a four-bit operation code and a single carry bit, which the surrounding core supplies from the lowest bit of its flag register. In the same cycle it returns a result word and four condition outputs: carry, zero, negative and overflow. An extra output marks an operation code that has no meaning.

The operation set covers plain and carry-chained addition and subtraction, four bitwise functions, three shift kinds, and multiplication. For multiplication, the upper or lower half of the double-width product can be selected, with the operands read as either unsigned or signed. The core instantiates the block between operand selection and write-back. It has no storage. The operand width is a parameter (default 32), and every internal width is derived from it.

Top module: `int_alu`

## Requirements
- R1: Code 0 returns A+B modulo 2^WIDTH. Code 1 returns A+B+carry_in modulo 2^WIDTH.
- R2: Code 2 returns A−B modulo 2^WIDTH. Code 3 returns A−B−carry_in modulo 2^WIDTH.
- R3: Codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A OR B), in that order.
- R4: Codes 8, 9 and 10 shift A by the amount held in the low log2(WIDTH) bits of B. Code 8 is a logical left shift, code 9 a logical right shift and code 10 an arithmetic right shift. The other bits of B have no effect.
- R5: Treating both operands as unsigned, code 11 returns the low WIDTH bits of the 2·WIDTH-bit product and code 12 returns the high WIDTH bits.
- R6: Treating both operands as two's-complement, code 13 returns the low WIDTH bits of the product and code 14 returns the high WIDTH bits.
- R7: Code 15 returns a result of zero with bad_op=1. Every other code gives bad_op=0.
- R8: For codes 0 and 1, carry_out is the carry out of the top bit. For codes 2 and 3 it is 1 exactly when no borrow occurs, that is when A ≥ B (+carry_in for code 3) as unsigned values. For all other codes it is 0.
- R9: For codes 0–3, ovf_out is 1 exactly when the signed result of the operation, taken as an exact integer, does not fit in WIDTH-bit two's-complement. For all other codes it is 0.
- R10: zero_out is 1 exactly when the result is all zeros. neg_out equals the top bit of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code, 0–15 |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand and shift amount |
| carry_in | input | 1 | Carry used by codes 1 and 3 |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry / not-borrow |
| zero_out | output | 1 | Result is zero |
| neg_out | output | 1 | Top bit of the result |
| ovf_out | output | 1 | Signed overflow of add/subtract |
| bad_op | output | 1 | Undefined operation code |

## Verification
Two cases are hard to reach with 32-bit random operands. The first is a subtract-with-borrow where carry_in alone decides the borrow, which needs A equal to B. The second is a signed high-word product of the most negative value with itself. Both are rare at full width. The bench therefore also builds a 4-bit copy of the unit and sweeps every operand pair, code and carry value on it, so every borrow boundary and overflow edge appears. The 32-bit copy is driven with the five extreme values in all pairings plus random operands.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD     = 4'd0,
    OP_ADDC    = 4'd1,
    OP_SUB     = 4'd2,
    OP_SUBC    = 4'd3,
    OP_AND     = 4'd4,
    OP_OR      = 4'd5,
    OP_XOR     = 4'd6,
    OP_NOR     = 4'd7,
    OP_SHL     = 4'd8,
    OP_SHR     = 4'd9,
    OP_SAR     = 4'd10,
    OP_MULU_LO = 4'd11,
    OP_MULU_HI = 4'd12,
    OP_MULS_LO = 4'd13,
    OP_MULS_HI = 4'd14,
    OP_BAD     = 4'd15
  } alu_op_e;

  // one-hot index of the functional unit feeding the result mux
  localparam int UNIT_ARITH = 0;
  localparam int UNIT_LOGIC = 1;
  localparam int UNIT_SHIFT = 2;
  localparam int UNIT_MULT  = 3;
  localparam int NUM_UNITS  = 4;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             use_carry,
  input  logic             is_sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  // full-width add with one extra bit for the carry
  function automatic logic [WIDTH:0] add_ext(input logic [WIDTH-1:0] x,
                                             input logic [WIDTH-1:0] y,
                                             input logic c0);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, c0};
  endfunction

  logic             chain_bit;  // carry bit that enters the chain (0 when unused)
  logic [WIDTH-1:0] b_eff;
  logic             c_first;
  logic [WIDTH:0]   raw;

  always_comb begin
    chain_bit = use_carry & cin;
    b_eff     = is_sub ? ~b : b;
    // a - b - k == a + ~b + (1 - k)
    c_first   = is_sub ? ~chain_bit : chain_bit;
    raw       = add_ext(a, b_eff, c_first);
    sum       = raw[WIDTH-1:0];
    cout      = raw[WIDTH];
    ovf       = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

  // a subtraction must be undone by adding b and the borrow back
  always_comb begin
    if (is_sub)
      p_sub_inverse_r2: assert ((sum + b + {{(WIDTH-1){1'b0}}, chain_bit}) == a)
        else $error("p_sub_inverse_r2");
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       fn,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] any_set;

  always_comb begin
    any_set = a | b;
    unique case (fn)
      2'd0: y = a & b;
      2'd1: y = any_set;
      2'd2: y = a ^ b;
      default: y = ~any_set;
    endcase
  end

  // xor and and partition the or: no overlap, union is the or
  always_comb begin
    if (fn == 2'd2)
      p_xor_partition_r3: assert (((y & (a & b)) == '0) && ((y | (a & b)) == (a | b)))
        else $error("p_xor_partition_r3");
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int WIDTH = 32,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SHW-1:0]   amt,
  input  logic [1:0]       kind,
  output logic [WIDTH-1:0] y
);

  logic [WIDTH-1:0] shl_v, shr_v, sar_v;

  always_comb begin
    shl_v = a << amt;
    shr_v = a >> amt;
    sar_v = WIDTH'($signed(a) >>> amt);
    unique case (kind)
      2'd0:    y = shl_v;
      2'd1:    y = shr_v;
      default: y = sar_v;
    endcase
  end

  // arithmetic and logical right shifts agree on non-negative input
  always_comb begin
    if (!a[WIDTH-1])
      p_sar_matches_shr_r4: assert (sar_v == shr_v) else $error("p_sar_matches_shr_r4");
  end

endmodule

// File: rtl/alu_mult.sv
module alu_mult #(
  parameter int WIDTH = 32,
  localparam int PW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [PW-1:0]    prod_u,
  output logic [PW-1:0]    prod_s
);

  function automatic logic [PW-1:0] mul_u(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    return {{WIDTH{1'b0}}, x} * {{WIDTH{1'b0}}, y};
  endfunction

  function automatic logic [PW-1:0] mul_s(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y);
    logic signed [PW-1:0] xs, ys;
    xs = $signed({{WIDTH{x[WIDTH-1]}}, x});
    ys = $signed({{WIDTH{y[WIDTH-1]}}, y});
    return PW'(xs * ys);
  endfunction

  always_comb begin
    prod_u = mul_u(a, b);
    prod_s = mul_s(a, b);
  end

  // low halves are independent of operand signedness
  always_comb begin
    p_low_half_agree_r6: assert (prod_u[WIDTH-1:0] == prod_s[WIDTH-1:0])
      else $error("p_low_half_agree_r6");
  end

endmodule

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero_out,
  output logic             neg_out,
  output logic             ovf_out,
  output logic             bad_op
);

  import int_alu_pkg::*;

  localparam int SHW = $clog2(WIDTH);
  localparam int PW  = 2 * WIDTH;

  alu_op_e              op;
  logic [NUM_UNITS-1:0] unit_sel;
  logic                 use_carry, is_sub;

  logic [WIDTH-1:0] as_sum, lg_y, sh_y;
  logic             as_cout, as_ovf;
  logic [PW-1:0]    prod_u, prod_s;
  logic [WIDTH-1:0] mul_y;

  // decode
  always_comb begin
    op        = alu_op_e'(op_sel);
    unit_sel  = '0;
    use_carry = (op == OP_ADDC) || (op == OP_SUBC);
    is_sub    = (op == OP_SUB)  || (op == OP_SUBC);
    bad_op    = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC:            unit_sel[UNIT_ARITH] = 1'b1;
      OP_AND, OP_OR, OP_XOR, OP_NOR:               unit_sel[UNIT_LOGIC] = 1'b1;
      OP_SHL, OP_SHR, OP_SAR:                      unit_sel[UNIT_SHIFT] = 1'b1;
      OP_MULU_LO, OP_MULU_HI, OP_MULS_LO, OP_MULS_HI: unit_sel[UNIT_MULT] = 1'b1;
      default:                                     bad_op = 1'b1;
    endcase
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(opnd_a), .b(opnd_b), .cin(carry_in), .use_carry(use_carry),
    .is_sub(is_sub), .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(opnd_a), .b(opnd_b), .fn(op_sel[1:0]), .y(lg_y)
  );

  alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a(opnd_a), .amt(opnd_b[SHW-1:0]), .kind(op_sel[1:0]), .y(sh_y)
  );

  alu_mult #(.WIDTH(WIDTH)) u_mult (
    .a(opnd_a), .b(opnd_b), .prod_u(prod_u), .prod_s(prod_s)
  );

  // multiply word select
  always_comb begin
    unique case (op)
      OP_MULU_LO: mul_y = prod_u[WIDTH-1:0];
      OP_MULU_HI: mul_y = prod_u[PW-1:WIDTH];
      OP_MULS_LO: mul_y = prod_s[WIDTH-1:0];
      default:    mul_y = prod_s[PW-1:WIDTH];
    endcase
  end

  // result mux and condition outputs
  always_comb begin
    result    = '0;
    carry_out = 1'b0;
    ovf_out   = 1'b0;
    if (unit_sel[UNIT_ARITH]) begin
      result    = as_sum;
      carry_out = as_cout;
      ovf_out   = as_ovf;
    end
    if (unit_sel[UNIT_LOGIC]) result = lg_y;
    if (unit_sel[UNIT_SHIFT]) result = sh_y;
    if (unit_sel[UNIT_MULT])  result = mul_y;
    zero_out = (result == '0);
    neg_out  = result[WIDTH-1];
  end

  always_comb begin
    p_unit_onehot_r7: assert ($onehot0(unit_sel) && (bad_op == (unit_sel == '0)))
      else $error("p_unit_onehot_r7");
    if (bad_op)
      p_bad_op_quiet_r7: assert ((result == '0) && !carry_out && !ovf_out && zero_out)
        else $error("p_bad_op_quiet_r7");
    p_zero_not_neg_r10: assert (!(zero_out && neg_out)) else $error("p_zero_not_neg_r10");
    if (!unit_sel[UNIT_ARITH])
      p_flags_idle_r9: assert (!carry_out && !ovf_out) else $error("p_flags_idle_r9");
  end

endmodule

// File: tb/int_alu_test.sv
module int_alu_test;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // full-width copy
  logic [3:0]  op_l = '0;
  logic [31:0] a_l = '0, b_l = '0, r_l;
  logic        c_l = 1'b0, co_l, z_l, n_l, v_l, bad_l;
  // 4-bit copy, swept exhaustively
  logic [3:0]  op_s = '0;
  logic [3:0]  a_s = '0, b_s = '0, r_s;
  logic        c_s = 1'b0, co_s, z_s, n_s, v_s, bad_s;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  int_alu #(.WIDTH(32)) uut (
    .op_sel(op_l), .opnd_a(a_l), .opnd_b(b_l), .carry_in(c_l),
    .result(r_l), .carry_out(co_l), .zero_out(z_l), .neg_out(n_l),
    .ovf_out(v_l), .bad_op(bad_l)
  );

  int_alu #(.WIDTH(4)) uut_small (
    .op_sel(op_s), .opnd_a(a_s), .opnd_b(b_s), .carry_in(c_s),
    .result(r_s), .carry_out(co_s), .zero_out(z_s), .neg_out(n_s),
    .ovf_out(v_s), .bad_op(bad_s)
  );

  typedef struct packed {
    logic [31:0] res;
    logic c, z, n, v, bad;
  } outs_t;

  function automatic string op_tag(input logic [3:0] op);
    if (op <= 4'd1)  return "R1";
    if (op <= 4'd3)  return "R2";
    if (op <= 4'd7)  return "R3";
    if (op <= 4'd10) return "R4";
    if (op <= 4'd12) return "R5";
    if (op <= 4'd14) return "R6";
    return "R7";
  endfunction

  // reference computed from exact integer arithmetic
  function automatic outs_t model(input int w, input logic [3:0] op,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic cin);
    outs_t e;
    logic [127:0] mask, ua, ub, t, p;
    logic signed [127:0] q;
    longint half, sa, sb, sr;
    int amt;
    logic [127:0] k;
    e    = '0;
    mask = (128'd1 << w) - 128'd1;
    ua   = {96'd0, a} & mask;
    ub   = {96'd0, b} & mask;
    half = longint'(1) << (w - 1);
    sa   = (ua >= 128'(half)) ? longint'(ua) - 2 * half : longint'(ua);
    sb   = (ub >= 128'(half)) ? longint'(ub) - 2 * half : longint'(ub);
    amt  = int'(ub % 128'(w));
    k    = 128'(((op == 4'd1) || (op == 4'd3)) ? cin : 1'b0);
    t    = '0;
    case (op)
      4'd0, 4'd1: begin
        t   = ua + ub + k;
        e.c = t[w];
        sr  = sa + sb + longint'(k);
        e.v = (sr > half - 1) || (sr < -half);
      end
      4'd2, 4'd3: begin
        t   = ua - ub - k;
        e.c = !(ua < ub + k);
        sr  = sa - sb - longint'(k);
        e.v = (sr > half - 1) || (sr < -half);
      end
      4'd4:  t = ua & ub;
      4'd5:  t = ua | ub;
      4'd6:  t = ua ^ ub;
      4'd7:  t = ~(ua | ub);
      4'd8:  t = ua << amt;
      4'd9:  t = ua >> amt;
      4'd10: begin sr = sa >>> amt; t = 128'(sr); end
      4'd11: begin p = ua * ub; t = p; end
      4'd12: begin p = ua * ub; t = p >> w; end
      4'd13: begin q = 128'(sa * sb); t = q; end
      4'd14: begin q = 128'(sa * sb); t = q >> w; end
      default: begin t = '0; e.bad = 1'b1; end
    endcase
    t     = t & mask;
    e.res = t[31:0];
    e.z   = (t == '0);
    e.n   = t[w-1];
    return e;
  endfunction

  task automatic apply(input int w, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic cin);
    outs_t e, g;
    bit bad;
    string t;
    @(posedge clk);
    if (w == 32) begin op_l = op; a_l = a; b_l = b; c_l = cin; end
    else begin op_s = op; a_s = a[3:0]; b_s = b[3:0]; c_s = cin; end
    @(negedge clk);
    e = model(w, op, a, b, cin);
    if (w == 32) g = '{r_l, co_l, z_l, n_l, v_l, bad_l};
    else         g = '{{28'd0, r_s}, co_s, z_s, n_s, v_s, bad_s};
    t = op_tag(op);
    bad = 1'b0;
    vectors++;
    if (g.res !== e.res) begin bad = 1'b1;
      $display("FAIL %s w=%0d op=%0d a=%h b=%h c=%b result act=%h exp=%h", t, w, op, a, b, cin, g.res, e.res); end
    if (g.bad !== e.bad) begin bad = 1'b1;
      $display("FAIL R7 w=%0d op=%0d bad_op act=%b exp=%b", w, op, g.bad, e.bad); end
    if (g.c !== e.c) begin bad = 1'b1;
      $display("FAIL R8 w=%0d op=%0d a=%h b=%h c=%b carry act=%b exp=%b", w, op, a, b, cin, g.c, e.c); end
    if (g.v !== e.v) begin bad = 1'b1;
      $display("FAIL R9 w=%0d op=%0d a=%h b=%h c=%b ovf act=%b exp=%b", w, op, a, b, cin, g.v, e.v); end
    if ((g.z !== e.z) || (g.n !== e.n)) begin bad = 1'b1;
      $display("FAIL R10 w=%0d op=%0d zero/neg act=%b%b exp=%b%b", w, op, g.z, g.n, e.z, e.n); end
    if (bad) miscompares++;
  endtask

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h0000_0000;
    corner[1] = 32'h0000_0001;
    corner[2] = 32'h7FFF_FFFF;
    corner[3] = 32'h8000_0000;
    corner[4] = 32'hFFFF_FFFF;

    // all-zero inputs: result zero, only zero_out raised (R1, R10)
    apply(32, 4'd0, 32'd0, 32'd0, 1'b0);

    // upper bits of the shift amount are ignored (R4)
    apply(32, 4'd8, 32'h0000_0003, 32'hFFFF_FFE4, 1'b0);
    apply(32, 4'd10, 32'h8000_0000, 32'h0000_003F, 1'b1);
    // borrow decided by carry_in alone (R2, R8)
    apply(32, 4'd3, 32'h1234_5678, 32'h1234_5678, 1'b1);
    // most negative squared (R6)
    apply(32, 4'd14, 32'h8000_0000, 32'h8000_0000, 1'b0);

    // exhaustive sweep of the 4-bit copy: R1..R10
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++)
            apply(4, 4'(op), 32'(a), 32'(b), 1'(c));

    // full width: corners in all pairings, then random operands
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int c = 0; c < 2; c++)
            apply(32, 4'(op), corner[i], corner[j], 1'(c));
      for (int r = 0; r < 150; r++)
        apply(32, 4'(op), $urandom, $urandom, 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired after %0d cycles", WD_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule